// File: doc/BRIEF.md
# Programmable Serial Clock Generator

This block derives the bit clock of a serial interface from a fast reference clock. Every stage runs as a clock enable in the reference domain. A power-of-two prescaler produces an enable pulse. An optional divide-by-3 stage thins that pulse train into a base tick. A phase-shaping state machine counts base ticks and drives the output level. When the divider is enabled, the period and the low time are programmed separately, so the duty cycle is under software control. When the divider is off, the output spends one base tick low and one base tick high.

The output is a registered level. A companion strobe is high for exactly one reference cycle after each rising edge of the output, so a serial engine can step on it without a second clock. All configuration inputs are live, but the block samples them only at the start of a period (the falling edge of the output), or on every cycle while it is stopped. A configuration change therefore never produces a short or stretched pulse.

The state machine has three states. S_OFF is the stopped state: the output is low and the configuration is reloaded every cycle. S_LOW counts the low phase, and S_HIGH counts the high phase. The transitions are as follows. S_OFF goes to S_LOW once the select is non-zero. S_LOW goes to S_HIGH on the base tick that ends the low phase, and this transition raises the strobe. S_HIGH goes to S_LOW on the base tick that ends the period, which is a boundary with a reload. S_HIGH goes to S_OFF at a boundary where the select is zero.

Top module: `serclk_gen`

## Requirements
- R1: While reset is asserted, and in the cycle after it, `sclk` and `sclk_rise` are low.
- R2: Select value n in 1..7 makes the base-tick interval T = 2^(n-1) reference cycles when divide-by-3 is off. Every phase length scales by T.
- R3: Select value 0 stops the clock at the next period boundary. After that boundary `sclk` stays low and `sclk_rise` never pulses.
- R4: With `div3_en` high, the base-tick interval becomes 3 * 2^(n-1) reference cycles.
- R5: With `div_en` high and `low_m1` < `period_m1`, the output is low for (`low_m1`+1)*T cycles and then high for (`period_m1`-`low_m1`)*T cycles.
- R6: With `div_en` high and `low_m1` >= `period_m1`, the output is low for the whole programmed period, (`period_m1`+1)*T cycles, and then high for T cycles.
- R7: With `div_en` low, the prescaled tick passes straight through: the output is low for T cycles and high for T cycles, whatever the period and low fields hold.
- R8: `sclk_rise` is high for exactly the first reference cycle in which `sclk` is high after being low, and low in every other cycle.
- R9: The configuration is captured only at the reference edge where `sclk` falls. A write during a period leaves that period's low and high lengths unchanged. A write held in the last cycle before the falling edge governs the period that starts at that edge.
- R10: From the stopped state, with a non-zero select first seen at a given edge, `sclk` rises (low phase length)*T cycles after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 3 | Prescale select: 0 stopped, n divides by 2^(n-1) |
| div3_en | input | 1 | Inserts the divide-by-3 stage |
| div_en | input | 1 | Enables the programmable period/low divider |
| period_m1 | input | 8 | Period in base ticks, minus one |
| low_m1 | input | 8 | Low time in base ticks, minus one |
| sclk | output | 1 | Generated serial clock level |
| sclk_rise | output | 1 | One-cycle strobe after each rising edge of `sclk` |

## Verification
The period-boundary reload and a configuration write can land on the same reference edge. To provoke this, the bench changes the settings in the last high sample of a period. The following low and high lengths must then match the new settings exactly. The bench also writes in the middle of a low phase, and that period must keep its old lengths. Together these pin down the capture point from both sides.

// File: rtl/serclk_pkg.sv
package serclk_pkg;

    localparam int SEL_W_DEF = 3;
    localparam int CNT_W_DEF = 8;

    typedef enum logic [1:0] {
        S_OFF  = 2'd0,
        S_LOW  = 2'd1,
        S_HIGH = 2'd2
    } phase_e;

endpackage

// File: rtl/serclk_prescale.sv
module serclk_prescale #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [SEL_W-1:0] sel,
    output logic             pre_en
);
    localparam int TAP_N = 1 << SEL_W;
    localparam int PRE_W = TAP_N - 2;

    logic [PRE_W-1:0] pcnt;
    logic [TAP_N-1:0] tap;
    logic [SEL_W-1:0] sel_m1;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) pcnt <= '0;
        else                 pcnt <= pcnt + 1'b1;
    end

    // tap[k] fires once every 2^k cycles; top tap unused (select 0 wraps there)
    assign tap[0]       = 1'b1;
    assign tap[TAP_N-1] = 1'b0;
    for (genvar i = 1; i <= PRE_W; i++) begin : g_tap
        assign tap[i] = &pcnt[i-1:0];
    end

    assign sel_m1 = sel - 1'b1;
    assign pre_en = tap[sel_m1];
endmodule

// File: rtl/serclk_div3.sv
module serclk_div3 (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic en3,
    input  logic pre_en,
    output logic tick
);
    logic [1:0] ph;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) ph <= 2'd0;
        else if (pre_en)     ph <= (ph == 2'd2) ? 2'd0 : ph + 2'd1;
    end

    assign tick = en3 ? (pre_en && ph == 2'd2) : pre_en;
endmodule

// File: rtl/serclk_shaper.sv
module serclk_shaper
    import serclk_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             div3_i,
    input  logic             div_en_i,
    input  logic [CNT_W-1:0] per_i,
    input  logic [CNT_W-1:0] low_i,
    input  logic             tick_i,
    output logic             load_o,
    output logic [SEL_W-1:0] sel_q_o,
    output logic             div3_q_o,
    output logic             off_o,
    output logic             sclk_o,
    output logic             rise_o
);
    phase_e           state, nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic [SEL_W-1:0] sel_q;
    logic             div3_q, den_q;
    logic [CNT_W-1:0] per_q, low_q;
    logic [CNT_W-1:0] lo_last, hi_last;
    logic             low_lt, load;

    // last tick index of each phase, from the captured settings
    assign low_lt  = low_q < per_q;
    assign lo_last = !den_q ? '0 : (low_lt ? low_q : per_q);
    assign hi_last = (den_q && low_lt) ? per_q - low_q - 1'b1 : '0;

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        load    = 1'b0;
        unique case (state)
            S_OFF: begin
                load    = 1'b1;
                cnt_nxt = '0;
                if (sel_i != '0) nxt = S_LOW;
            end
            S_LOW: begin
                if (tick_i) begin
                    if (cnt == lo_last) begin
                        nxt     = S_HIGH;
                        cnt_nxt = '0;
                    end else begin
                        cnt_nxt = cnt + 1'b1;
                    end
                end
            end
            S_HIGH: begin
                if (tick_i) begin
                    if (cnt == hi_last) begin
                        load    = 1'b1;
                        cnt_nxt = '0;
                        nxt     = (sel_i != '0) ? S_LOW : S_OFF;
                    end else begin
                        cnt_nxt = cnt + 1'b1;
                    end
                end
            end
            default: nxt = S_OFF;
        endcase
    end

    // state register, phase counter and captured configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_OFF;
            cnt    <= '0;
            sel_q  <= '0;
            div3_q <= 1'b0;
            den_q  <= 1'b0;
            per_q  <= '0;
            low_q  <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
            if (load) begin
                sel_q  <= sel_i;
                div3_q <= div3_i;
                den_q  <= div_en_i;
                per_q  <= per_i;
                low_q  <= low_i;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_o <= 1'b0;
            rise_o <= 1'b0;
        end else begin
            sclk_o <= (nxt == S_HIGH);
            rise_o <= (state == S_LOW) && (nxt == S_HIGH);
        end
    end

    assign load_o   = load;
    assign sel_q_o  = sel_q;
    assign div3_q_o = div3_q;
    assign off_o    = (state == S_OFF);
endmodule

// File: rtl/serclk_gen.sv
module serclk_gen
    import serclk_pkg::*;
#(
    parameter int SEL_W = SEL_W_DEF,
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] src_sel,
    input  logic             div3_en,
    input  logic             div_en,
    input  logic [CNT_W-1:0] period_m1,
    input  logic [CNT_W-1:0] low_m1,
    output logic             sclk,
    output logic             sclk_rise
);
    logic             restart;
    logic [SEL_W-1:0] sel_act;
    logic             div3_act;
    logic             pre_en;
    logic             base_tick;
    logic             phase_off;

    serclk_prescale #(.SEL_W(SEL_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (restart),
        .sel    (sel_act),
        .pre_en (pre_en)
    );

    serclk_div3 u_div3 (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (restart),
        .en3    (div3_act),
        .pre_en (pre_en),
        .tick   (base_tick)
    );

    serclk_shaper #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_shape (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (src_sel),
        .div3_i   (div3_en),
        .div_en_i (div_en),
        .per_i    (period_m1),
        .low_i    (low_m1),
        .tick_i   (base_tick),
        .load_o   (restart),
        .sel_q_o  (sel_act),
        .div3_q_o (div3_act),
        .off_o    (phase_off),
        .sclk_o   (sclk),
        .rise_o   (sclk_rise)
    );
endmodule

// File: rtl/serclk_gen_chk.sv
module serclk_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic rise,
    input logic tick,
    input logic off
);
    // R8: strobe only in the first high cycle
    p_rise_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> (sclk && !$past(sclk)));

    // R8: no strobe on a falling edge
    p_fall_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> !rise);

    // R2: the output level only moves on a base tick
    p_edge_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk != $past(sclk)) |-> $past(tick));

    // R3: stopped state keeps the output quiet
    p_off_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        off |-> (!sclk && !rise));
endmodule

bind serclk_gen serclk_gen_chk u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .sclk (sclk),
    .rise (sclk_rise),
    .tick (base_tick),
    .off  (phase_off)
);

// File: tb/serclk_gen_test.sv
`timescale 1ns/1ps
module serclk_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sel;
    logic       d3, den;
    logic [7:0] per, low;
    logic       sclk, rise;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    // configuration applied from inside a measurement
    int p_sel, p_d3, p_den, p_per, p_low;

    always #4 clk = ~clk;

    serclk_gen uut (
        .clk(clk), .rst_n(rst_n), .src_sel(sel), .div3_en(d3), .div_en(den),
        .period_m1(per), .low_m1(low), .sclk(sclk), .sclk_rise(rise)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1..all actual=%0d expected<=150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic setcfg(input int s, input int dd, input int de, input int p, input int l);
        sel = 3'(s); d3 = dd[0]; den = de[0]; per = 8'(p); low = 8'(l);
    endtask

    task automatic apply_pend();
        setcfg(p_sel, p_d3, p_den, p_per, p_low);
    endtask

    function automatic int tick_len(input int s, input int dd);
        return (1 << (s - 1)) * (dd != 0 ? 3 : 1);
    endfunction
    function automatic int lo_ticks(input int de, input int p, input int l);
        if (de == 0) return 1;
        return (l < p) ? l + 1 : p + 1;
    endfunction
    function automatic int hi_ticks(input int de, input int p, input int l);
        if (de == 0) return 1;
        return (l < p) ? p - l : 1;
    endfunction

    task automatic sync_fall(input string req);
        bit prev;
        int g;
        prev = sclk;
        g = 0;
        forever begin
            @(negedge clk);
            if (prev && !sclk) break;
            prev = sclk;
            g++;
            if (g > 20000) begin
                chk(1'b0, req, g, 0);
                break;
            end
        end
    endtask

    // entered at the first low sample of a period; leaves at the next one
    task automatic measure(input int lo_wr, input int hi_wr,
                           output int lo, output int hi, output bit rok);
        lo = 1;
        hi = 0;
        rok = !rise;
        if (lo == lo_wr) apply_pend();
        forever begin
            @(negedge clk);
            if (sclk || lo > 20000) break;
            lo++;
            if (rise) rok = 1'b0;
            if (lo == lo_wr) apply_pend();
        end
        if (!rise) rok = 1'b0;
        hi = 1;
        if (hi == hi_wr) apply_pend();
        forever begin
            @(negedge clk);
            if (!sclk || hi > 20000) break;
            hi++;
            if (rise) rok = 1'b0;
            if (hi == hi_wr) apply_pend();
        end
    endtask

    initial begin
        int lo, hi, t, el, eh, z, bad;
        bit rok;
        int pv[6] = '{3, 4, 2, 0, 7, 5};
        int lv[6] = '{1, 0, 5, 0, 2, 1};
        int dv[6] = '{1, 1, 1, 1, 1, 0};
        string req;

        setcfg(1, 0, 1, 3, 1);
        repeat (3) @(negedge clk);
        chk(sclk == 1'b0, "R1 sclk in reset", sclk, 0);
        chk(rise == 1'b0, "R1 strobe in reset", rise, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sclk == 1'b0, "R1 sclk after reset", sclk, 0);

        // sweep: every select, with and without divide-by-3, several shapes
        for (int s = 1; s <= 7; s++) begin
            for (int dd = 0; dd <= 1; dd++) begin
                for (int k = 0; k < 6; k++) begin
                    setcfg(s, dd, dv[k], pv[k], lv[k]);
                    sync_fall("R9 sync");
                    measure(-1, -1, lo, hi, rok);
                    t  = tick_len(s, dd);
                    el = lo_ticks(dv[k], pv[k], lv[k]) * t;
                    eh = hi_ticks(dv[k], pv[k], lv[k]) * t;
                    if (dv[k] == 0)         req = "R7";
                    else if (lv[k] >= pv[k]) req = "R6";
                    else                    req = "R5";
                    chk(lo == el, $sformatf("%s/R2/R4 low sel=%0d d3=%0d k=%0d", req, s, dd, k), lo, el);
                    chk(hi == eh, $sformatf("%s/R2/R4 high sel=%0d d3=%0d k=%0d", req, s, dd, k), hi, eh);
                    chk(rok, $sformatf("R8 strobe sel=%0d d3=%0d k=%0d", s, dd, k), rok, 1);
                end
            end
        end

        // R9: mid-period write must not alter the running period
        setcfg(2, 0, 1, 5, 1);
        sync_fall("R9 sync");
        p_sel = 1; p_d3 = 0; p_den = 1; p_per = 2; p_low = 0;
        measure(2, -1, lo, hi, rok);
        chk(lo == 4, "R9 old low kept", lo, 4);
        chk(hi == 8, "R9 old high kept", hi, 8);
        // R9: write in the last high cycle lands on the boundary
        p_sel = 1; p_d3 = 0; p_den = 1; p_per = 3; p_low = 2;
        measure(-1, 2, lo, hi, rok);
        chk(lo == 1, "R9 new low active", lo, 1);
        chk(hi == 2, "R9 new high active", hi, 2);
        measure(-1, -1, lo, hi, rok);
        chk(lo == 3, "R9 same-cycle write low", lo, 3);
        chk(hi == 1, "R9 same-cycle write high", hi, 1);
        chk(rok, "R8 strobe after boundary write", rok, 1);

        // R3: select 0 stops at the next boundary
        setcfg(0, 0, 1, 3, 1);
        sync_fall("R3 sync");
        bad = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (sclk || rise) bad++;
        end
        chk(bad == 0, "R3 stopped output quiet", bad, 0);

        // R10: restart latency from the stopped state
        setcfg(3, 1, 1, 4, 1);
        z = 0;
        forever begin
            @(negedge clk);
            if (sclk || z > 5000) break;
            z++;
        end
        chk(z == 24, "R10 first rise latency", z, 24);
        chk(rise == 1'b1, "R8 strobe on restart rise", rise, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule